// File: doc/BRIEF.md
# Timeslot Codec Control Port

This block is the serial side of a telephone filter/codec: the part that moves one PCM byte in each direction per frame and takes in control words that set gain, loopback, powerdown and a set of general-purpose outputs. Everything runs from the single bit clock. An active-low slot enable marks the bit periods that belong to this device. During an enabled slot of eight bit periods the block shifts one byte in on the PCM input and one byte in on the control input. In the same eight periods it drives the transmit byte out on the PCM output. Outside its slot the PCM output is released.

A two-bit address input stands in for a three-level address pin. It decides where a serial control word lands. In the low code the word goes to the function register and the auxiliary register is wiped. In the mid code the word goes to the function register and the auxiliary register is left alone. In the high code the word goes to the auxiliary register, and the PCM transfer of that slot is suppressed. When the address is low, a separate mode input can turn the control pin into a static level instead of a serial stream. In that case a low level means normal operation at 0 dB and a high level means powerdown. A controller that wants to write both registers every frame opens two slots: the first with the low or mid code, the second with the high code.

The serial pins carry no back-pressure. The slot enable alone paces the data, and a word is never held or retried. The received PCM byte is offered with a one-cycle strobe that cannot be stalled.

Top module: `tsc_ctrl_port`

## Requirements
- R1: After reset, `pcm_oe`, `pcm_out`, `rx_strobe`, `pwr_down`, `loopback`, `tx_gain`, `rx_gain`, `gp_out` and `test_sel` are all zero.
- R2: A slot is eight bit periods with `slot_en_n` low. Bits arrive MSB first and are sampled on the falling clock edge. A register changes only at the falling edge that samples the eighth bit.
- R3: While a slot transfers PCM, `pcm_oe` is high for exactly its eight bit periods, and `pcm_out` presents `tx_byte` MSB first, changing on rising edges. At all other times `pcm_oe` and `pcm_out` are low.
- R4: After a slot that transfers PCM, the byte shifted in on `pcm_in` appears on `rx_byte`, and `rx_strobe` is high for exactly one clock cycle.
- R5: Static mode applies when `addr_sel`=00 and `ctl_serial`=0. With `ctl_in` low, every function field reads zero (gain code 000 = 0 dB, no loopback, no powerdown). With `ctl_in` high, `pwr_down` is 1.
- R6: Function word layout: bit 7 is powerdown, bit 6 is loopback, bits 5:3 are transmit gain and bits 2:0 are receive gain.
- R7: With `addr_sel`=00 and `ctl_serial`=1, a complete word loads the function register and clears the auxiliary register to zero.
- R8: With `addr_sel`=01 or 11, a complete word loads the function register and the auxiliary register keeps its value.
- R9: With `addr_sel`=10, a complete word loads the auxiliary register and the function register keeps its value. That slot has no PCM output and no `rx_strobe`.
- R10: Auxiliary word layout: bits 5:0 drive `gp_out` and bits 7:6 drive `test_sel`. `test_sel` reads 00 whenever `addr_sel`=00.
- R11: While `pwr_down` is 1, a slot drives no PCM output and raises no `rx_strobe`, but its control word is still accepted.
- R12: If `slot_en_n` rises before the eighth bit, the partial word is discarded: no register changes and no `rx_strobe`.
- R13: With `slot_en_n` held low for sixteen periods, the block handles two consecutive words. The address present at the end of each word decides where that word goes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; inputs sampled on falling edge, PCM output changes on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_en_n | input | 1 | Active-low slot enable |
| addr_sel | input | 2 | Address level: 00 low, 01 mid, 10 high, 11 same as mid |
| ctl_serial | input | 1 | With addr_sel=00: 1 = control pin is serial, 0 = static level |
| ctl_in | input | 1 | Control pin (serial word or static level) |
| pcm_in | input | 1 | Serial PCM receive data |
| tx_byte | input | 8 | PCM byte to transmit in the next slot |
| pcm_out | output | 1 | Serial PCM transmit data |
| pcm_oe | output | 1 | Drive enable for pcm_out (low = high impedance) |
| rx_byte | output | 8 | Last PCM byte received |
| rx_strobe | output | 1 | One-cycle pulse when rx_byte is updated |
| pwr_down | output | 1 | Powerdown flag |
| loopback | output | 1 | Loopback enable |
| tx_gain | output | 3 | Transmit gain code |
| rx_gain | output | 3 | Receive gain code |
| gp_out | output | 6 | General-purpose outputs |
| test_sel | output | 2 | Test-mode entry bits |

## Verification
The bench writes the auxiliary register first. It then writes with the mid code and with code 11, and finally with the low serial code. A design that mixed up keep and clear would show the wrong value on `gp_out`, and a design that decoded code 11 as high would stop the PCM byte and leave the gains unchanged. A five-bit slot is used to catch a design that commits a partial word or fails to reset its bit counter. A sixteen-period slot with the address changed halfway is used to catch a counter that does not wrap, and a design that samples the address at the start of the slot. Powerdown is set both by a serial bit and by the static level. A design that drives the line or strobes a byte while powered down is then caught by the scoreboard, which flags any byte it was not told to expect.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  localparam int unsigned WORD_W = 8;
  localparam int unsigned GAIN_W = 3;
  localparam int unsigned GP_W   = 6;
  localparam int unsigned TEST_W = 2;

  typedef enum logic [1:0] {
    ADDR_LOW     = 2'b00,
    ADDR_MID     = 2'b01,
    ADDR_HIGH    = 2'b10,
    ADDR_MID_ALT = 2'b11
  } addr_lvl_e;

  typedef struct packed {
    logic              pdn;
    logic              lpbk;
    logic [GAIN_W-1:0] tx_gain;
    logic [GAIN_W-1:0] rx_gain;
  } func_word_t;

  typedef struct packed {
    logic [TEST_W-1:0] test;
    logic [GP_W-1:0]   gp;
  } aux_word_t;

  typedef struct packed {
    logic to_func;
    logic to_aux;
    logic clr_aux;
    logic pcm_ok;
  } route_t;

  function automatic route_t decode_route(addr_lvl_e lvl);
    route_t r;
    case (lvl)
      ADDR_LOW:  r = '{to_func: 1'b1, to_aux: 1'b0, clr_aux: 1'b1, pcm_ok: 1'b1};
      ADDR_HIGH: r = '{to_func: 1'b0, to_aux: 1'b1, clr_aux: 1'b0, pcm_ok: 1'b0};
      default:   r = '{to_func: 1'b1, to_aux: 1'b0, clr_aux: 1'b0, pcm_ok: 1'b1};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tsc_slot_rx.sv
module tsc_slot_rx #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_en_n,
  input  logic              ctl_bit,
  input  logic              pcm_bit,
  output logic              done,
  output logic [WORD_W-1:0] ctl_word,
  output logic [WORD_W-1:0] pcm_word
);
  localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-2:0] ctl_sr_q;
  logic [WORD_W-2:0] pcm_sr_q;

  // Falling-edge sampling; counter restarts whenever the slot closes.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      ctl_sr_q <= '0;
      pcm_sr_q <= '0;
    end else if (slot_en_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q    <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      ctl_sr_q <= {ctl_sr_q[WORD_W-3:0], ctl_bit};
      pcm_sr_q <= {pcm_sr_q[WORD_W-3:0], pcm_bit};
    end
  end

  assign done     = !slot_en_n && (cnt_q == LAST);
  assign ctl_word = {ctl_sr_q, ctl_bit};
  assign pcm_word = {pcm_sr_q, pcm_bit};

endmodule

// File: rtl/tsc_reg_bank.sv
module tsc_reg_bank
  import tsc_pkg::*;
#(
  parameter int unsigned WORD_W = tsc_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [WORD_W-1:0] ctl_word,
  input  addr_lvl_e         lvl,
  input  logic              ctl_serial,
  input  logic              ctl_level,
  output func_word_t        func_q,
  output aux_word_t         aux_q
);
  route_t route;
  logic   static_mode;

  assign route       = decode_route(lvl);
  assign static_mode = (lvl == ADDR_LOW) && !ctl_serial;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_q <= '0;
    end else if (static_mode) begin
      func_q <= func_word_t'({ctl_level, {(WORD_W-1){1'b0}}});
    end else if (done && route.to_func) begin
      func_q <= func_word_t'(ctl_word);
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aux_q <= '0;
    end else if (done && !static_mode) begin
      if (route.clr_aux)     aux_q <= '0;
      else if (route.to_aux) aux_q <= aux_word_t'(ctl_word);
    end
  end

endmodule

// File: rtl/tsc_pcm_tx.sv
module tsc_pcm_tx #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_en_n,
  input  logic              allow,
  input  logic [WORD_W-1:0] tx_byte,
  output logic              pcm_out,
  output logic              pcm_oe
);
  localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-2:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sh_q    <= '0;
      pcm_out <= 1'b0;
      pcm_oe  <= 1'b0;
    end else if (slot_en_n) begin
      cnt_q   <= '0;
      pcm_out <= 1'b0;
      pcm_oe  <= 1'b0;
    end else begin
      cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      pcm_oe <= allow;
      if (cnt_q == '0) begin
        sh_q    <= tx_byte[WORD_W-2:0];
        pcm_out <= allow & tx_byte[WORD_W-1];
      end else begin
        sh_q    <= {sh_q[WORD_W-3:0], 1'b0};
        pcm_out <= allow & sh_q[WORD_W-2];
      end
    end
  end

endmodule

// File: rtl/tsc_ctrl_port.sv
module tsc_ctrl_port
  import tsc_pkg::*;
#(
  parameter int unsigned WORD_W = tsc_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_en_n,
  input  logic [1:0]        addr_sel,
  input  logic              ctl_serial,
  input  logic              ctl_in,
  input  logic              pcm_in,
  input  logic [WORD_W-1:0] tx_byte,
  output logic              pcm_out,
  output logic              pcm_oe,
  output logic [WORD_W-1:0] rx_byte,
  output logic              rx_strobe,
  output logic              pwr_down,
  output logic              loopback,
  output logic [GAIN_W-1:0] tx_gain,
  output logic [GAIN_W-1:0] rx_gain,
  output logic [GP_W-1:0]   gp_out,
  output logic [TEST_W-1:0] test_sel
);
  addr_lvl_e         lvl;
  route_t            route;
  logic              done;
  logic [WORD_W-1:0] ctl_word;
  logic [WORD_W-1:0] pcm_word;
  func_word_t        func_q;
  aux_word_t         aux_q;
  logic              pcm_allow;

  assign lvl       = addr_lvl_e'(addr_sel);
  assign route     = decode_route(lvl);
  assign pcm_allow = route.pcm_ok && !func_q.pdn;

  tsc_slot_rx #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .slot_en_n(slot_en_n),
    .ctl_bit(ctl_in), .pcm_bit(pcm_in),
    .done(done), .ctl_word(ctl_word), .pcm_word(pcm_word)
  );

  tsc_reg_bank #(.WORD_W(WORD_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .done(done), .ctl_word(ctl_word),
    .lvl(lvl), .ctl_serial(ctl_serial), .ctl_level(ctl_in),
    .func_q(func_q), .aux_q(aux_q)
  );

  tsc_pcm_tx #(.WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .slot_en_n(slot_en_n),
    .allow(pcm_allow), .tx_byte(tx_byte),
    .pcm_out(pcm_out), .pcm_oe(pcm_oe)
  );

  // Received byte is handed over at the falling edge that completes the slot.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte   <= '0;
      rx_strobe <= 1'b0;
    end else begin
      rx_strobe <= done && pcm_allow;
      if (done && pcm_allow) rx_byte <= pcm_word;
    end
  end

  assign pwr_down = func_q.pdn;
  assign loopback = func_q.lpbk;
  assign tx_gain  = func_q.tx_gain;
  assign rx_gain  = func_q.rx_gain;
  assign gp_out   = aux_q.gp;
  assign test_sel = (lvl == ADDR_LOW) ? '0 : aux_q.test;

endmodule

// File: rtl/tsc_ctrl_port_chk.sv
module tsc_ctrl_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       slot_en_n,
  input logic [1:0] addr_sel,
  input logic       pcm_out,
  input logic       pcm_oe,
  input logic       rx_strobe,
  input logic       pwr_down,
  input logic       loopback,
  input logic [2:0] tx_gain,
  input logic [2:0] rx_gain,
  input logic [5:0] gp_out
);
  AST_OE_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_oe |-> $past(!slot_en_n)); // R3

  AST_LINE_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pcm_oe |-> !pcm_out); // R3

  AST_PD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pwr_down) |-> !pcm_oe); // R11

  AST_HIGH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(addr_sel == 2'b10) |-> !pcm_oe); // R9

  AST_FUNC_HOLD: assert property (@(negedge clk) disable iff (!rst_n)
    (addr_sel == 2'b10) |=> $stable({pwr_down, loopback, tx_gain, rx_gain})); // R9

  AST_AUX_HOLD: assert property (@(negedge clk) disable iff (!rst_n)
    (addr_sel == 2'b01 || addr_sel == 2'b11) |=> $stable(gp_out)); // R8

  AST_STROBE_ONE: assert property (@(negedge clk) disable iff (!rst_n)
    rx_strobe |=> !rx_strobe); // R4

endmodule

bind tsc_ctrl_port tsc_ctrl_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .slot_en_n(slot_en_n), .addr_sel(addr_sel),
  .pcm_out(pcm_out), .pcm_oe(pcm_oe), .rx_strobe(rx_strobe),
  .pwr_down(pwr_down), .loopback(loopback), .tx_gain(tx_gain),
  .rx_gain(rx_gain), .gp_out(gp_out)
);

// File: tb/tsc_ctrl_port_bench.sv
module tsc_ctrl_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slot_en_n = 1'b1;
  logic [1:0] addr_sel = 2'b00;
  logic       ctl_serial = 1'b0;
  logic       ctl_in = 1'b0;
  logic       pcm_in = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic       pcm_out, pcm_oe, rx_strobe, pwr_down, loopback;
  logic [7:0] rx_byte;
  logic [2:0] tx_gain, rx_gain;
  logic [5:0] gp_out;
  logic [1:0] test_sel;

  int vectors = 0;
  int miscompares = 0;
  int rx_cnt = 0;
  logic [7:0] rx_last = 8'h00;
  logic [7:0] exp_q[$];
  logic [7:0] mon_bits = 8'h00;
  int mon_n = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  tsc_ctrl_port u_tsc_ctrl_port (
    .clk(clk), .rst_n(rst_n), .slot_en_n(slot_en_n), .addr_sel(addr_sel),
    .ctl_serial(ctl_serial), .ctl_in(ctl_in), .pcm_in(pcm_in), .tx_byte(tx_byte),
    .pcm_out(pcm_out), .pcm_oe(pcm_oe), .rx_byte(rx_byte), .rx_strobe(rx_strobe),
    .pwr_down(pwr_down), .loopback(loopback), .tx_gain(tx_gain), .rx_gain(rx_gain),
    .gp_out(gp_out), .test_sel(test_sel)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: rebuilds transmitted bytes and compares against the scoreboard.
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (pcm_oe) begin
        mon_bits = {mon_bits[6:0], pcm_out};
        mon_n++;
        if (mon_n == 8) begin
          if (exp_q.size() == 0) check("R3", "unexpected PCM byte", {24'd0, mon_bits}, 32'hFFFF_FFFF);
          else check("R3", "PCM byte on line", {24'd0, mon_bits}, {24'd0, exp_q.pop_front()});
          mon_n = 0;
        end
      end else begin
        mon_n = 0;
      end
      if (rx_strobe) begin
        rx_cnt++;
        rx_last = rx_byte;
      end
    end
  end

  // Driver: one slot of nbits; inputs change just after the falling edge.
  task automatic slot(input logic [1:0] sel, input logic ser, input logic [7:0] cw,
                      input logic [7:0] pw, input logic [7:0] tb, input int nbits,
                      input bit expect_out);
    if (expect_out) exp_q.push_back(tb);
    @(negedge clk); #1;
    addr_sel = sel; ctl_serial = ser; tx_byte = tb; slot_en_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      ctl_in = cw[7-i]; pcm_in = pw[7-i];
      @(negedge clk); #1;
    end
    slot_en_n = 1'b1; ctl_in = 1'b0; pcm_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic settle();
    @(posedge clk); #1;
  endtask

  initial begin
    int rx0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    settle();
    // R1 reset state
    check("R1", "pcm_oe", pcm_oe, 0);
    check("R1", "pcm_out", pcm_out, 0);
    check("R1", "rx_strobe", rx_strobe, 0);
    check("R1", "func", {pwr_down, loopback, tx_gain, rx_gain}, 0);
    check("R1", "aux", {test_sel, gp_out}, 0);

    // R2 R3 R4 R5: static low, normal PCM transfer at 0 dB
    rx0 = rx_cnt;
    slot(2'b00, 1'b0, 8'h00, 8'h3C, 8'hA5, 8, 1);
    settle();
    check("R4", "rx strobes", rx_cnt - rx0, 1);
    check("R4", "rx byte", rx_last, 8'h3C);
    check("R5", "static low func", {pwr_down, loopback, tx_gain, rx_gain}, 0);

    // R9 R10: high code writes aux, no PCM, function kept
    rx0 = rx_cnt;
    slot(2'b10, 1'b1, 8'hC7, 8'h11, 8'h22, 8, 0);
    settle();
    check("R10", "gp_out", gp_out, 6'h07);
    check("R10", "test_sel", test_sel, 2'b11);
    check("R9", "func kept", {pwr_down, loopback, tx_gain, rx_gain}, 0);
    check("R9", "no rx strobe", rx_cnt - rx0, 0);

    // R6 R8: mid code loads function, aux kept
    slot(2'b01, 1'b1, 8'h5B, 8'h81, 8'h96, 8, 1);
    settle();
    check("R6", "loopback", loopback, 1);
    check("R6", "tx_gain", tx_gain, 3);
    check("R6", "rx_gain", rx_gain, 3);
    check("R6", "pwr_down", pwr_down, 0);
    check("R8", "aux kept mid", {test_sel, gp_out}, 8'hC7);
    check("R4", "rx byte mid", rx_last, 8'h81);

    // R8: code 11 behaves as mid
    slot(2'b11, 1'b1, 8'h2E, 8'h44, 8'h0F, 8, 1);
    settle();
    check("R8", "code11 tx_gain", tx_gain, 5);
    check("R8", "code11 rx_gain", rx_gain, 6);
    check("R8", "code11 aux kept", gp_out, 6'h07);

    // R12: partial word discarded
    rx0 = rx_cnt;
    slot(2'b01, 1'b1, 8'hFF, 8'hFF, 8'hFF, 5, 0);
    settle();
    check("R12", "func unchanged", {pwr_down, loopback, tx_gain, rx_gain}, 8'h2E);
    check("R12", "no rx strobe", rx_cnt - rx0, 0);

    // R7: low serial code loads function and clears aux
    slot(2'b00, 1'b1, 8'h12, 8'h5A, 8'h3A, 8, 1);
    settle();
    check("R7", "func loaded", {pwr_down, loopback, tx_gain, rx_gain}, 8'h12);
    check("R7", "aux cleared", gp_out, 0);
    addr_sel = 2'b01;
    settle();
    check("R10", "test_sel after clear", test_sel, 0);

    // R11: serial powerdown; next slot silent but still accepts a word
    slot(2'b01, 1'b1, 8'h80, 8'h66, 8'hC3, 8, 1);
    settle();
    check("R11", "pwr_down set", pwr_down, 1);
    rx0 = rx_cnt;
    slot(2'b01, 1'b1, 8'h00, 8'h77, 8'hE1, 8, 0);
    settle();
    check("R11", "no rx strobe", rx_cnt - rx0, 0);
    check("R11", "word accepted", pwr_down, 0);

    // R13: two back-to-back words in one 16-period window
    exp_q.push_back(8'h69);
    rx0 = rx_cnt;
    @(negedge clk); #1;
    tx_byte = 8'h69; ctl_serial = 1'b1; addr_sel = 2'b01; slot_en_n = 1'b0;
    for (int i = 0; i < 16; i++) begin
      if (i == 8) addr_sel = 2'b10;
      ctl_in = (i < 8) ? 8'h1B >> (7 - i) : 8'h85 >> (15 - i);
      pcm_in = (i < 8) ? 8'hD2 >> (7 - i) : 1'b1;
      @(negedge clk); #1;
    end
    slot_en_n = 1'b1; ctl_in = 1'b0;
    repeat (3) @(negedge clk);
    settle();
    check("R13", "first word func", {loopback, tx_gain, rx_gain}, 7'h1B);
    check("R13", "second word aux", {test_sel, gp_out}, 8'h85);
    check("R13", "one rx strobe", rx_cnt - rx0, 1);
    check("R13", "rx byte", rx_last, 8'hD2);

    // R5: static high forces powerdown, then static low restores
    @(negedge clk); #1;
    addr_sel = 2'b00; ctl_serial = 1'b0; ctl_in = 1'b1;
    repeat (2) settle();
    check("R5", "static high pwr_down", pwr_down, 1);
    rx0 = rx_cnt;
    slot(2'b00, 1'b0, 8'hFF, 8'h99, 8'h5D, 8, 0);
    settle();
    check("R11", "static pd no strobe", rx_cnt - rx0, 0);
    @(negedge clk); #1 ctl_in = 1'b0;
    repeat (2) settle();
    check("R5", "static low restore", {pwr_down, loopback, tx_gain, rx_gain}, 0);

    check("R3", "scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule